// File: doc/BRIEF.md
# Register-Mapped General Purpose I/O Unit

This block gives a processor control of sixteen general purpose pins through a small register bus. Software reaches four word registers. The pin-direction register holds one bit per pin, and a pin drives only while its bit is 0. The output value register gives the level each driving pin carries. The pin level register is read-only and returns the synchronized pin inputs. The interrupt mask register selects which pins may raise the processor interrupt. Pad electronics sit outside the block. For each pin the block provides an output value and an active-high drive enable, and it takes in the sampled pad level.

A strap input selects endpoint mode. In that mode the four lowest pins leave register control. They are always driven, and each carries the inverse of one of four interrupt request inputs. Each pin can also serve as an interrupt input. A pin with its mask bit set requests an interrupt while its synchronized level is low. The single interrupt output is the OR of all such requests.

Reset is asynchronous on assertion and is released through a two-stage synchronizer. Every pin is released to high impedance from the moment reset asserts until the internal reset lifts. The pin level register keeps sampling throughout reset, so it holds the pin states when software first looks.

Top module: `gpio_unit`

## Requirements
- R1: Outside reset and outside endpoint mode, pin i drives (`pin_oe[i]`=1) with `pin_out[i]` equal to bit i of the output value register only when bit i of the direction register is 0. A 1 in that bit releases the pin (`pin_oe[i]`=0).
- R2: After reset the direction register reads 0xFFFF, the output value register reads 0x0000 and the interrupt mask register reads 0x0000.
- R3: `pin_oe` is all zeros while `rst_n` is low, and it stays all zeros until the second rising clock edge after `rst_n` rises, whatever the register contents.
- R4: A read of offset 0x4 returns the pin levels sampled two rising edges earlier. Sampling continues while reset is asserted.
- R5: With `ep_mode`=1, pins 3:0 are driven (`pin_oe[3:0]`=4'hF) and `pin_out[i]` = ~`irq_req[i]` for i in 0..3, regardless of the registers. Pins 15:4 still follow R1.
- R6: The direction register sits at byte offset 0x0, the output value register at 0x8 and the interrupt mask register at 0xC. All three are read/write. A write with `reg_wr`=1 takes effect at the next rising edge, and reads are combinational on `reg_addr`.
- R7: Writes to offset 0x4 or to any other offset are ignored. Reads of any offset other than 0x0, 0x4, 0x8 and 0xC return 0.
- R8: `cpu_irq` is 1 exactly when some pin has its mask bit set and a synchronized level of 0.
- R9: Register writes made while the internal reset is still asserted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational on `reg_addr` |
| ep_mode | input | 1 | Endpoint strap; gives pins 3:0 to the interrupt request lines |
| irq_req | input | 4 | Active-high requests sent active-low on pins 3:0 in endpoint mode |
| pin_in | input | 16 | Sampled pad levels |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad drive enables, 1 = drive |
| cpu_irq | output | 1 | Combined level interrupt to the processor |

## Verification
A corrupted direction or output value bit shows up on `pin_oe` or `pin_out` in the same cycle it is stored, and a read of that register shows it as well. A fault in the synchronizer depth shows in the pin level readback and in `cpu_irq` one clock early or one clock late, so a bench that compares every clock against a model with exact latency sees it at once. A reset-release fault opens the pads while they should still be held at high impedance. Writes issued in the first cycles after reset expose it immediately.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned GPIO_W  = 16;
  localparam int unsigned GPIO_AW = 4;
  localparam int unsigned GPIO_NQ = 4;
  localparam logic [GPIO_AW-1:0] OFS_DIR = 4'h0;
  localparam logic [GPIO_AW-1:0] OFS_LVL = 4'h4;
  localparam logic [GPIO_AW-1:0] OFS_VAL = 4'h8;
  localparam logic [GPIO_AW-1:0] OFS_MSK = 4'hC;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] meta_q, lvl_q;

  // Free running: keeps sampling while reset is held.
  always_ff @(posedge clk) begin
    meta_q <= pin_i;
    lvl_q  <= meta_q;
  end

  assign lvl_o = lvl_q;

  // R4: level register lags the pins by two edges
  assert_level_lag_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    lvl_q == $past(pin_i, 2));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W  = GPIO_W,
  parameter int unsigned AW = GPIO_AW
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  lvl_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  dir_o,
  output logic [W-1:0]  val_o,
  output logic [W-1:0]  msk_o
);
  logic [W-1:0] dir_q, dir_d, val_q, val_d, msk_q, msk_d;
  logic         dir_en, val_en, msk_en;

  always_comb begin
    dir_en = wr_i && (addr_i == OFS_DIR);
    val_en = wr_i && (addr_i == OFS_VAL);
    msk_en = wr_i && (addr_i == OFS_MSK);
    dir_d  = dir_en ? wdata_i : dir_q;
    val_d  = val_en ? wdata_i : val_q;
    msk_d  = msk_en ? wdata_i : msk_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      val_q <= '0;
      msk_q <= '0;
    end else begin
      dir_q <= dir_d;
      val_q <= val_d;
      msk_q <= msk_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_DIR: rdata_o = dir_q;
      OFS_LVL: rdata_o = lvl_i;
      OFS_VAL: rdata_o = val_q;
      OFS_MSK: rdata_o = msk_q;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign val_o = val_q;
  assign msk_o = msk_q;

  // R6: a write to the direction offset lands next cycle
  assert_dir_write_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_DIR) |=> (dir_q == $past(wdata_i)));

  // R7: writes elsewhere leave all storage untouched
  assert_ignored_write_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && addr_i != OFS_DIR && addr_i != OFS_VAL && addr_i != OFS_MSK)
      |=> ($stable(dir_q) && $stable(val_q) && $stable(msk_q)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned W  = 16,
  parameter int unsigned NQ = 4
) (
  input  logic          rst_ni,
  input  logic          ep_i,
  input  logic [NQ-1:0] irq_req_i,
  input  logic [W-1:0]  dir_i,
  input  logic [W-1:0]  val_i,
  output logic [W-1:0]  pin_o,
  output logic [W-1:0]  pin_oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i < NQ) begin : g_shared
      assign pin_o[i]    = ep_i ? ~irq_req_i[i] : val_i[i];
      assign pin_oe_o[i] = rst_ni & (ep_i | ~dir_i[i]);
    end else begin : g_plain
      assign pin_o[i]    = val_i[i];
      assign pin_oe_o[i] = rst_ni & ~dir_i[i];
    end
  end
endmodule

// File: rtl/gpio_unit.sv
module gpio_unit
  import gpio_pkg::*;
#(
  parameter int unsigned W  = GPIO_W,
  parameter int unsigned AW = GPIO_AW,
  parameter int unsigned NQ = GPIO_NQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          ep_mode,
  input  logic [NQ-1:0] irq_req,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          cpu_irq
);
  logic         rst_n_int;
  logic [W-1:0] lvl, dir, val, msk;

  gpio_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_n_int));

  gpio_in_sync #(.W(W)) i_sync (
    .clk(clk), .rst_ni(rst_n_int), .pin_i(pin_in), .lvl_o(lvl));

  gpio_regs #(.W(W), .AW(AW)) i_regs (
    .clk(clk), .rst_ni(rst_n_int), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .lvl_i(lvl), .rdata_o(reg_rdata),
    .dir_o(dir), .val_o(val), .msk_o(msk));

  gpio_pad_mux #(.W(W), .NQ(NQ)) i_mux (
    .rst_ni(rst_n_int), .ep_i(ep_mode), .irq_req_i(irq_req),
    .dir_i(dir), .val_i(val), .pin_o(pin_out), .pin_oe_o(pin_oe));

  assign cpu_irq = |(msk & ~lvl);

  // R5: endpoint strap owns the low pins
  assert_ep_pins_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    ep_mode |-> (pin_oe[NQ-1:0] == '1 && pin_out[NQ-1:0] == ~irq_req));

  // R3: pads released while the internal reset holds
  assert_hiz_reset_R3: assert property (@(posedge clk) disable iff (rst_n_int)
    1'b1 |-> (pin_oe == '0));
endmodule

// File: tb/test_gpio_unit.sv
module test_gpio_unit;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        ep_mode;
  logic [3:0]  irq_req;
  logic [15:0] pin_in, pin_out, pin_oe;
  logic        cpu_irq;

  int n_cmp = 0, n_bad = 0;
  bit chk_en = 1'b0, done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  gpio_unit i_gpio_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ep_mode(ep_mode),
    .irq_req(irq_req), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .cpu_irq(cpu_irq));

  // Behavioural reference model
  logic [1:0]  m_rs;
  logic [15:0] m_dir, m_val, m_msk;
  logic [15:0] m_hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs  <= 2'b00;
      m_dir <= 16'hFFFF;
      m_val <= 16'h0000;
      m_msk <= 16'h0000;
    end else begin
      if (m_rs[1] && reg_wr) begin  // R9: no writes before release
        if (reg_addr == 4'h0) m_dir <= reg_wdata;
        if (reg_addr == 4'h8) m_val <= reg_wdata;
        if (reg_addr == 4'hC) m_msk <= reg_wdata;
      end
      m_rs <= {m_rs[0], 1'b1};
    end
  end

  always @(posedge clk) begin
    m_hist.push_back(pin_in);
    if (m_hist.size() > 2) void'(m_hist.pop_front());
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      automatic logic        ok  = m_rs[1] && rst_n;
      automatic logic [15:0] lv  = m_hist[0];
      automatic logic [15:0] eoe = 16'h0;
      automatic logic [15:0] eout = 16'h0;
      automatic logic [15:0] erd;
      automatic string       t;
      for (int i = 0; i < 16; i++) begin
        if (ep_mode && i < 4) begin
          eoe[i] = ok; eout[i] = ~irq_req[i];
        end else begin
          eoe[i] = ok & ~m_dir[i]; eout[i] = m_val[i];
        end
      end
      t = !ok ? "R3" : (ep_mode ? "R5" : "R1");
      chk({t, " pin_oe"}, pin_oe, eoe);
      chk({t, " pin_out"}, pin_out & eoe, eout & eoe);
      case (reg_addr)
        4'h0: begin erd = m_dir; t = ok ? "R6" : "R2"; end
        4'h4: begin erd = lv;    t = "R4"; end
        4'h8: begin erd = m_val; t = ok ? "R6" : "R2"; end
        4'hC: begin erd = m_msk; t = ok ? "R6" : "R2"; end
        default: begin erd = 16'h0; t = "R7"; end
      endcase
      chk({t, " rdata"}, reg_rdata, erd);
      chk("R8 cpu_irq", {15'h0, cpu_irq}, {15'h0, |(m_msk & ~lv)});
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; step();
    reg_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = 16'h0;
    ep_mode = 1'b0; irq_req = 4'h0; pin_in = 16'hA5C3;
    step(3);
    chk_en = 1'b1;
    // R2/R3/R4: reset values, pads released, sampling during reset
    for (int a = 0; a < 16; a += 4) begin reg_addr = a[3:0]; step(); end
    pin_in = 16'h3C5A; reg_addr = 4'h4; step(3);
    // R9: writes while reset held and just after release are dropped
    reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 16'hFFFF; step();
    rst_n = 1'b1; reg_addr = 4'h0; reg_wdata = 16'h0000; step(1);
    reg_wr = 1'b0; step(2);
    // R6/R1: drive low byte with a pattern
    wr(4'h8, 16'h5A3C); wr(4'h0, 16'hFF00); wr(4'hC, 16'h8001);
    for (int a = 0; a < 16; a++) begin reg_addr = a[3:0]; step(); end
    // R8: interrupt from masked low pins
    pin_in = 16'hFFFF; step(3);
    pin_in = 16'hFFFE; step(3);
    pin_in = 16'h7FFF; step(3);
    pin_in = 16'hBFFD; step(3);
    // R7: writes to read-only and unmapped offsets
    wr(4'h4, 16'h1234); wr(4'h6, 16'h0000); wr(4'hF, 16'h0000); wr(4'h1, 16'h0);
    for (int a = 0; a < 16; a += 4) begin reg_addr = a[3:0]; step(); end
    // R5: endpoint mode with all pins configured as inputs
    wr(4'h0, 16'hFFFF);
    ep_mode = 1'b1;
    for (int k = 0; k < 16; k++) begin irq_req = k[3:0]; step(); end
    wr(4'h0, 16'h00F0); irq_req = 4'hA; step(2);
    ep_mode = 1'b0; step(2);
    // Mid-run reset, then R2 values again
    rst_n = 1'b0; step(2); rst_n = 1'b1;
    for (int a = 0; a < 16; a += 4) begin reg_addr = a[3:0]; step(); end
    // Mixed random traffic
    for (int k = 0; k < 400; k++) begin
      reg_wr = $urandom_range(0, 1) == 1;
      reg_addr = $urandom_range(0, 15);
      if ($urandom_range(0, 3) == 0) reg_addr = 4'h0;
      reg_wdata = $urandom;
      pin_in = $urandom;
      ep_mode = $urandom_range(0, 7) == 0;
      irq_req = $urandom;
      if (k == 200) rst_n = 1'b0;
      if (k == 203) rst_n = 1'b1;
      step();
    end
    reg_wr = 1'b0; step(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule